// File: doc/BRIEF.md
# Pointer-Managed RAM Stack

This block keeps a last-in, first-out stack of data words in a small synchronous memory inside the block. A pointer register always holds the address of the entry that is currently on top, not the next free slot. An empty flag separates the empty stack from a stack that holds one word, because the pointer reads zero in both cases.

A client raises a push request with a word on the data input, or a pop request, for one cycle. A pushed word goes to address 0 when the stack is empty. Otherwise the pointer advances first and the word is written at the new address. A pop reads the word under the pointer into a registered output, which is valid one cycle later, and then steps the pointer back. Requests that cannot be served are dropped: a push into a full stack, and a pop from an empty one. When push and pop are raised in the same cycle, the cycle is treated as a pop.

Top module: `lifo_ram_stack`

## Requirements
- R1: After a synchronous active-low reset the pointer reads 0, the empty flag is 1, the full flag is 0 and the data output is 0.
- R2: A push into an empty stack writes the word at address 0, leaves the pointer at 0 and clears the empty flag in the next cycle.
- R3: A push into a non-empty stack first advances the pointer by one and then writes the word at the new address. Pushing 7, 4, 9 and 8 into an empty stack leaves the pointer at 3 with 8 on top.
- R4: An accepted pop places the word stored at the pointer address on the data output in the cycle after the request. When the pointer is above 0 it decreases by one in that same cycle.
- R5: Popping the last entry returns the word at address 0, leaves the pointer at 0 and sets the empty flag.
- R6: The full flag is 1 exactly when the stack is not empty and the pointer equals DEPTH-1 (15 by default). A push while full is ignored: the pointer does not change and the top word stays the same.
- R7: A pop while the stack is empty is ignored: the pointer stays 0, the empty flag stays 1 and the data output keeps its previous value.
- R8: When push and pop are requested in the same cycle, only the pop takes effect and the pushed word is discarded.
- R9: Over a full-depth fill followed by a complete drain, words come out in the reverse of the order in which they went in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| wdata_i | input | DATA_W | Word to push |
| rdata_o | output | DATA_W | Registered word from the last accepted pop |
| sp_o | output | $clog2(DEPTH) | Address of the current top entry |
| empty_o | output | 1 | Stack holds no entries |
| full_o | output | 1 | Stack holds DEPTH entries |

## Verification
Pointer, empty and full flags change on the first rising edge after a request. The popped word also appears on the output at that edge, because it passes through one register. The driver applies each request on a falling edge and withdraws it just after the next rising edge. It then samples the pointer and the flags on the following falling edge, half a cycle after they settle. The monitor notes at each rising edge whether an accepted pop was in flight, and on the next falling edge compares the output with the front of the scoreboard queue. For dropped pops, the bench checks on that same falling edge that the output still holds the previously popped word.

// File: rtl/lifo_stk_pkg.sv
// Package lifo_stk_pkg
// Holds the shared types of the pointer-managed stack.
// Assumes: requests are decoded into one operation per cycle.
package lifo_stk_pkg;

    // One decoded stack operation per clock cycle
    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

endpackage

// File: rtl/lifo_stk_ctrl.sv
// Module lifo_stk_ctrl
// Turns raw push/pop requests into one accepted operation.
// Pop has priority over push. A pop into an empty stack and a push into
// a full stack both become idle.
// Assumes: empty and full come from registered pointer state.
module lifo_stk_ctrl
    import lifo_stk_pkg::*;
(
    input  logic    push_req,
    input  logic    pop_req,
    input  logic    empty,
    input  logic    full,
    output stk_op_e op
);

    // Choose the accepted operation for this cycle
    always_comb begin
        if (pop_req && !empty) begin
            op = STK_POP;
        end else if (push_req && !pop_req && !full) begin
            op = STK_PUSH;
        end else begin
            op = STK_IDLE;
        end
    end

endmodule

// File: rtl/lifo_stk_ptr.sv
// Module lifo_stk_ptr
// Top-of-stack pointer with an empty flag. The pointer addresses the
// occupied top entry. It is 0 both when the stack is empty and when it
// holds one entry; the empty flag tells these two cases apart.
// Assumes: op is already filtered so that no push reaches a full stack
// and no pop reaches an empty one.
module lifo_stk_ptr
    import lifo_stk_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] wr_addr,
    output logic          empty,
    output logic          full
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] sp_q;
    logic          empty_q;

    // Move the pointer and the empty flag on each accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q    <= '0;
            empty_q <= 1'b1;
        end else begin
            case (op)
                STK_PUSH: begin
                    if (empty_q) begin
                        empty_q <= 1'b0;
                    end else begin
                        sp_q <= sp_q + AW'(1);
                    end
                end
                STK_POP: begin
                    if (sp_q == '0) begin
                        empty_q <= 1'b1;
                    end else begin
                        sp_q <= sp_q - AW'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Write target: the base slot when empty, otherwise one above the top
    assign wr_addr = empty_q ? sp_q : sp_q + AW'(1);
    assign sp      = sp_q;
    assign empty   = empty_q;
    assign full    = !empty_q && (sp_q == LAST);

    // R2: first push into an empty stack stays at address 0
    p_first_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_PUSH && empty) |=> (sp == '0 && !empty));

    // R3: later pushes advance the pointer by one
    p_push_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_PUSH && !empty) |=> (sp == $past(sp) + AW'(1)));

    // R4: a pop above the base steps the pointer back
    p_pop_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_POP && sp != '0) |=> (sp == $past(sp) - AW'(1) && !empty));

    // R5: popping the base entry empties the stack
    p_last_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_POP && sp == '0) |=> (empty && sp == '0));

    // R6: a full stack does not move on a push
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && op != STK_POP) |=> (full && $stable(sp)));

endmodule

// File: rtl/lifo_stk_mem.sv
// Module lifo_stk_mem
// Synchronous single-clock memory with one write port and one registered
// read port. The storage array has no reset; only the read register does.
// Assumes: write and read are never enabled in the same cycle.
module lifo_stk_mem #(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 16,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Store the pushed word
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Capture the popped word; hold it when no read is enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= store[raddr];
        end
    end

    assign rdata = rdata_q;

    // R7: the read register only changes on an enabled read
    p_hold_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));

endmodule

// File: rtl/lifo_ram_stack.sv
// Module lifo_ram_stack
// Top of the pointer-managed stack. It connects the request decoder, the
// top-of-stack pointer and the memory. A push writes at the slot that
// the pointer module computes. A pop reads at the current pointer.
// Assumes: one request at a time is served; pop wins over push.
module lifo_ram_stack
    import lifo_stk_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int DEPTH  = 16,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [AW-1:0]     sp_o,
    output logic              empty_o,
    output logic              full_o
);

    stk_op_e       op;
    logic [AW-1:0] sp;
    logic [AW-1:0] wr_addr;
    logic          empty;
    logic          full;

    lifo_stk_ctrl u_ctrl (
        .push_req (push_i),
        .pop_req  (pop_i),
        .empty    (empty),
        .full     (full),
        .op       (op)
    );

    lifo_stk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .sp      (sp),
        .wr_addr (wr_addr),
        .empty   (empty),
        .full    (full)
    );

    lifo_stk_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (op == STK_PUSH),
        .waddr (wr_addr),
        .wdata (wdata_i),
        .re    (op == STK_POP),
        .raddr (sp),
        .rdata (rdata_o)
    );

    assign sp_o    = sp;
    assign empty_o = empty;
    assign full_o  = full;

    // R7: a pop into an empty stack changes nothing visible
    p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o) |=> ($stable(rdata_o) && empty_o && sp_o == '0));

    // R8: a combined request behaves as a pop and never advances the pointer
    p_both_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o && sp_o != '0) |=> (sp_o == $past(sp_o) - AW'(1)));

    // R6: a push into a full stack leaves the pointer where it was
    p_full_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> $stable(sp_o));

endmodule

// File: tb/lifo_ram_stack_tb_top.sv
`timescale 1ns/1ps
module lifo_ram_stack_tb_top;

    localparam int W = 8;
    localparam int D = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_i = 1'b0;
    logic         pop_i = 1'b0;
    logic [W-1:0] wdata_i = '0;
    logic [W-1:0] rdata_o;
    logic [3:0]   sp_o;
    logic         empty_o;
    logic         full_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model and scoreboard
    logic [W-1:0] mdl [D];
    int           mcnt = 0;
    logic [W-1:0] exp_q [$];
    string        tag_q [$];
    logic [W-1:0] last_rd = '0;
    bit           pop_now = 0;

    always #2.5 clk = ~clk;

    lifo_ram_stack #(.DATA_W(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .sp_o(sp_o),
        .empty_o(empty_o), .full_o(full_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare pointer and flags with the model
    task automatic chk_state(input string req);
        chk(req, "sp", int'(sp_o), (mcnt == 0) ? 0 : mcnt - 1);
        chk(req, "empty", int'(empty_o), (mcnt == 0) ? 1 : 0);
        chk(req, "full", int'(full_o), (mcnt == D) ? 1 : 0);
    endtask

    // Driver: apply one request, update the model, queue the expected word
    task automatic op(input bit ps, input bit pp, input logic [W-1:0] d, input string req);
        @(negedge clk);
        push_i  = ps;
        pop_i   = pp;
        wdata_i = d;
        pop_now = 0;
        if (pp && mcnt > 0) begin
            mcnt--;
            exp_q.push_back(mdl[mcnt]);
            tag_q.push_back(req);
            pop_now = 1;
        end else if (ps && !pp && mcnt < D) begin
            mdl[mcnt] = d;
            mcnt++;
        end
        @(posedge clk);
        #1;
        push_i  = 0;
        pop_i   = 0;
        pop_now = 0;
        @(negedge clk);
        chk_state(req);
    endtask

    // Monitor: compare the popped word one cycle after an accepted pop
    initial begin
        forever begin
            bit take;
            @(posedge clk);
            take = pop_now;
            @(negedge clk);
            if (take && exp_q.size() > 0) begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "rdata", int'(rdata_o), int'(e));
                last_rd = e;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "sp", int'(sp_o), 0);
        chk("R1", "empty", int'(empty_o), 1);
        chk("R1", "full", int'(full_o), 0);
        chk("R1", "rdata", int'(rdata_o), 0);

        // R7: pop on empty is ignored and output holds
        op(0, 1, 8'h00, "R7");
        chk("R7", "rdata hold", int'(rdata_o), int'(last_rd));

        // R2 then R3: 7,4,9,8
        op(1, 0, 8'd7, "R2");
        op(1, 0, 8'd4, "R3");
        op(1, 0, 8'd9, "R3");
        op(1, 0, 8'd8, "R3");
        chk("R3", "sp after four", int'(sp_o), 3);

        // R4 and R5: drain
        op(0, 1, 8'h00, "R4");
        op(0, 1, 8'h00, "R4");
        op(0, 1, 8'h00, "R4");
        op(0, 1, 8'h00, "R5");
        chk("R5", "empty after last", int'(empty_o), 1);
        chk("R5", "rdata base word", int'(rdata_o), 7);

        // R7 again after a real pop: output keeps 7
        op(0, 1, 8'h00, "R7");
        chk("R7", "rdata hold", int'(rdata_o), 7);

        // R9 and R6: fill to full depth
        for (int i = 0; i < D; i++) begin
            op(1, 0, W'(i * 3 + 1), "R9");
        end
        chk("R6", "full", int'(full_o), 1);
        op(1, 0, 8'hEE, "R6");
        chk("R6", "sp held", int'(sp_o), D - 1);
        op(0, 1, 8'h00, "R6");

        // R8: combined request acts as a pop
        op(1, 1, 8'h55, "R8");
        op(0, 1, 8'h00, "R8");

        // R9: drain the rest in reverse order
        while (mcnt > 0) begin
            op(0, 1, 8'h00, "R9");
        end
        chk("R9", "empty after drain", int'(empty_o), 1);

        // R2: base slot reused after drain
        op(1, 0, 8'hA5, "R2");
        op(0, 1, 8'h00, "R2");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule